// File: doc/BRIEF.md
# Triple Match-Compare Timer

This peripheral holds three independent 32-bit sub-timers behind one word-wide register bus. Each sub-timer has a live counter, a reload value and two compare values. It counts up or down by one on every cycle where the shared tick-enable input is high and its own enable bit is set. When a counter reaches its limit, it reloads. When a counter moves past a compare value, the block records the event in a shared status register. It also pulses the combined interrupt line and the line that belongs to the sub-timer.

Software sets up the compare and reload values, writes a start value into the counter, and starts the sub-timer through the shared control word. It services events by reading the status word and writing ones to acknowledge them. A mask word keeps an event in the status word while holding back its interrupt pulse. Reads are combinational. A write takes effect at the clock edge where `wr_en` is high.

Top module: `tri_timer`

## Requirements
- R1: Sub-timer n (0..2) decodes at byte offset 16·n. Its counter is at +0x0, reload at +0x4, compare A at +0x8 and compare B at +0xC. The control word is at 0x30, status at 0x34 and mask at 0x38, and each of these reads back what was written. Control keeps only bits 3n, 3n+2 and 9+n, so a read returns 0xF6D after writing all ones. Mask and status keep bits 8..0. A read of 0x3C returns 0x00010801. Any other offset, including one with a nonzero low address pair, reads zero and ignores writes. `rdata` is zero whenever `rd_en` is low.
- R2: Reset clears every counter, reload, compare, control, status and mask register, and both interrupt outputs.
- R3: A sub-timer steps by exactly one on a cycle where `tick_en` is high and control bit 3n is set. It counts up when control bit 9+n is set and down when that bit is clear. On any other cycle the counter holds.
- R4: A write to a counter wins over counting in the same cycle. The new value appears in the counter and both compares re-arm.
- R5: A counting tick that finds an up-counter at 0xFFFFFFFF, or a down-counter at 0, loads the counter from its reload register instead of stepping.
- R6: On such a wrap, status bit 3n+2 is set only when control bit 3n+2 is set. The reload happens either way.
- R7: Compare A sets status bit 3n and compare B sets bit 3n+1. A compare fires on the step whose new value is greater than or equal to it in up mode, or less than or equal to it in down mode. Each compare fires at most once per pass and re-arms on a wrap, on any control write or on a counter write.
- R8: Writing the status word clears the bits written as one and keeps the others. An event in the same cycle still sets its bit.
- R9: An event of sub-timer n drives `irq_sub[n]` and `irq_all` high for exactly the cycle after the event edge, unless the event's mask bit (same position as its status bit) is set. A masked event is still recorded in status.
- R10: The three sub-timers run at the same time without affecting one another's counters, compares or status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Single-cycle count enable shared by all sub-timers |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero when idle |
| irq_all | output | 1 | Combined interrupt pulse |
| irq_sub | output | 3 | Per-sub-timer interrupt pulses |

## Verification
The bench keeps its own arithmetic model of all three sub-timers and steps it alongside the design through several phases:
- up counting with a wrap,
- down counting with the overflow event disabled,
- masked counting,
- a phase where all three run with irregular tick gaps.

It aims at a few corner cases:
- A compare value already passed at start-up must fire on the very first step. A design that waited for equality would never fire it.
- A counter write and a status clear that land on a tick must resolve by the stated priorities. A design with the wrong order would lose an event or keep a stale count.
- A down-counter must pass through zero before it reloads, and the wrap must respect the overflow enable. An off-by-one limit check would shift every later counter read.
- A compare must not fire again until it is re-armed. A design that re-fired would show repeated interrupt pulses.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

  localparam int TMR_CNT    = 3;
  localparam int DATA_W     = 32;
  localparam int EV_PER_TMR = 3;
  localparam int EV_W       = TMR_CNT * EV_PER_TMR;
  localparam int CTRL_W     = EV_W + TMR_CNT;

  localparam logic [DATA_W-1:0] REV_WORD = 32'h0001_0801;

  // word slots inside the shared window (byte offsets 0x30..0x3C)
  localparam logic [1:0] SH_CTRL = 2'd0;
  localparam logic [1:0] SH_STAT = 2'd1;
  localparam logic [1:0] SH_MASK = 2'd2;
  localparam logic [1:0] SH_REV  = 2'd3;

  typedef enum logic [1:0] {
    SLOT_CNT = 2'd0,
    SLOT_RLD = 2'd1,
    SLOT_MA  = 2'd2,
    SLOT_MB  = 2'd3
  } slot_e;

  // field order matches the status word layout of one sub-timer
  typedef struct packed {
    logic ovf;
    logic hit_b;
    logic hit_a;
  } tmr_ev_t;

  function automatic logic [DATA_W-1:0] next_count(input logic [DATA_W-1:0] v,
                                                   input logic up);
    return up ? v + 1'b1 : v - 1'b1;
  endfunction

  function automatic logic at_limit(input logic [DATA_W-1:0] v, input logic up);
    return up ? (&v) : (~|v);
  endfunction

  function automatic logic match_hit(input logic [DATA_W-1:0] v,
                                     input logic [DATA_W-1:0] m,
                                     input logic up);
    return up ? (v >= m) : (v <= m);
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_defined();
    logic [CTRL_W-1:0] k;
    k = '0;
    for (int n = 0; n < TMR_CNT; n++) begin
      k[EV_PER_TMR*n]     = 1'b1;
      k[EV_PER_TMR*n + 2] = 1'b1;
      k[EV_W + n]         = 1'b1;
    end
    return k;
  endfunction

endpackage

// File: rtl/tri_timer_chan.sv
module tri_timer_chan
  import tri_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              up,
  input  logic              ovf_en,
  input  logic              rearm,
  input  logic              wr_hit,
  input  slot_e             wr_slot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] rld_q,
  output logic [DATA_W-1:0] ma_q,
  output logic [DATA_W-1:0] mb_q,
  output tmr_ev_t           ev
);

  logic wr_cnt, wr_rld, wr_ma, wr_mb;
  logic wrap, stepping, hit_a, hit_b;
  logic arm_a, arm_b;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    wr_cnt   = wr_hit && (wr_slot == SLOT_CNT);
    wr_rld   = wr_hit && (wr_slot == SLOT_RLD);
    wr_ma    = wr_hit && (wr_slot == SLOT_MA);
    wr_mb    = wr_hit && (wr_slot == SLOT_MB);
    nxt      = next_count(cnt_q, up);
    wrap     = run && !wr_cnt && at_limit(cnt_q, up);
    stepping = run && !wr_cnt && !wrap;
    hit_a    = stepping && arm_a && match_hit(nxt, ma_q, up);
    hit_b    = stepping && arm_b && match_hit(nxt, mb_q, up);
    ev.hit_a = hit_a;
    ev.hit_b = hit_b;
    ev.ovf   = wrap && ovf_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (wr_cnt)   cnt_q <= wdata;
    else if (wrap)     cnt_q <= rld_q;
    else if (stepping) cnt_q <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '0;
      ma_q  <= '0;
      mb_q  <= '0;
    end else begin
      if (wr_rld) rld_q <= wdata;
      if (wr_ma)  ma_q  <= wdata;
      if (wr_mb)  mb_q  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_a <= 1'b1;
      arm_b <= 1'b1;
    end else if (wr_cnt || wrap || rearm) begin
      arm_a <= 1'b1;
      arm_b <= 1'b1;
    end else begin
      if (hit_a) arm_a <= 1'b0;
      if (hit_b) arm_b <= 1'b0;
    end
  end

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stepping |=> cnt_q == ($past(up) ? $past(cnt_q) + 32'd1 : $past(cnt_q) - 32'd1));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt_q));

  assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wdata));

  assert_wrap_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == $past(rld_q));

  assert_match_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && !rearm) |=> !hit_a);

  assert_match_once_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_b && !rearm) |=> !hit_b);

endmodule

// File: rtl/tri_timer_irq.sv
module tri_timer_irq
  import tri_timer_pkg::*;
#(
  parameter int N = TMR_CNT,
  parameter int W = EV_PER_TMR * N
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         clr_wr,
  input  logic         mask_wr,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] status_q,
  output logic [W-1:0] mask_q,
  output logic [N-1:0] irq_sub,
  output logic         irq_all
);

  logic [N-1:0] fire;
  logic [W-1:0] clr;

  for (genvar n = 0; n < N; n++) begin : g_fire
    assign fire[n] = |(ev[EV_PER_TMR*n +: EV_PER_TMR] & ~mask_q[EV_PER_TMR*n +: EV_PER_TMR]);

    assert_pulse_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_sub[n] |-> |status_q[EV_PER_TMR*n +: EV_PER_TMR]);

    assert_mask_silences_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev[EV_PER_TMR*n +: EV_PER_TMR] & ~mask_q[EV_PER_TMR*n +: EV_PER_TMR]) == '0)
        |=> !irq_sub[n]);
  end

  assign clr = clr_wr ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_sub  <= '0;
      irq_all  <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr) | ev;
      if (mask_wr) mask_q <= wbits;
      irq_sub  <= fire;
      irq_all  <= |fire;
    end
  end

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ev == '0) |=> status_q == ($past(status_q) & ~$past(wbits)));

  assert_event_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((status_q & $past(ev)) == $past(ev)));

  assert_all_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_all |-> (irq_sub != '0));

endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int ADDR_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_all,
  output logic [TMR_CNT-1:0] irq_sub
);

  localparam logic [CTRL_W-1:0] CTRL_KEEP = ctrl_defined();
  localparam logic [1:0]        SHARED_WIN = 2'(TMR_CNT);

  logic [31:0]        addr_ext;
  logic               in_map;
  logic [1:0]         win_idx;
  slot_e              slot;
  logic               shared;
  logic               ctrl_wr, stat_wr, mask_wr;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [EV_W-1:0]    ev_all;
  logic [EV_W-1:0]    status_q, mask_q;
  logic [DATA_W-1:0]  cnt_a [TMR_CNT];
  logic [DATA_W-1:0]  rld_a [TMR_CNT];
  logic [DATA_W-1:0]  ma_a  [TMR_CNT];
  logic [DATA_W-1:0]  mb_a  [TMR_CNT];

  // address decode: 16-byte windows, last window holds shared words
  always_comb begin
    addr_ext = 32'(addr);
    in_map   = (addr_ext < 32'd64) && (addr[1:0] == 2'b00);
    win_idx  = addr[5:4];
    slot     = slot_e'(addr[3:2]);
    shared   = in_map && (win_idx == SHARED_WIN);
    ctrl_wr  = wr_en && shared && (slot == SH_CTRL);
    stat_wr  = wr_en && shared && (slot == SH_STAT);
    mask_wr  = wr_en && shared && (slot == SH_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata[CTRL_W-1:0] & CTRL_KEEP;
  end

  for (genvar n = 0; n < TMR_CNT; n++) begin : g_tmr
    tmr_ev_t ev_n;

    tri_timer_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (tick_en && ctrl_q[EV_PER_TMR*n]),
      .up      (ctrl_q[EV_W + n]),
      .ovf_en  (ctrl_q[EV_PER_TMR*n + 2]),
      .rearm   (ctrl_wr),
      .wr_hit  (wr_en && in_map && (win_idx == 2'(n))),
      .wr_slot (slot),
      .wdata   (wdata),
      .cnt_q   (cnt_a[n]),
      .rld_q   (rld_a[n]),
      .ma_q    (ma_a[n]),
      .mb_q    (mb_a[n]),
      .ev      (ev_n)
    );

    assign ev_all[EV_PER_TMR*n +: EV_PER_TMR] = ev_n;
  end

  tri_timer_irq #(.N(TMR_CNT), .W(EV_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_all),
    .clr_wr   (stat_wr),
    .mask_wr  (mask_wr),
    .wbits    (wdata[EV_W-1:0]),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_sub  (irq_sub),
    .irq_all  (irq_all)
  );

  always_comb begin
    rdata = '0;
    if (rd_en && in_map) begin
      if (win_idx == SHARED_WIN) begin
        case (addr[3:2])
          SH_CTRL: rdata = DATA_W'(ctrl_q);
          SH_STAT: rdata = DATA_W'(status_q);
          SH_MASK: rdata = DATA_W'(mask_q);
          default: rdata = REV_WORD;
        endcase
      end else begin
        case (slot)
          SLOT_CNT: rdata = cnt_a[win_idx];
          SLOT_RLD: rdata = rld_a[win_idx];
          SLOT_MA:  rdata = ma_a[win_idx];
          default:  rdata = mb_a[win_idx];
        endcase
      end
    end
  end

  always_comb begin
    if (!rd_en) assert_idle_read_zero_R1: assert (rdata == '0);
  end

  assert_rev_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr_ext == 32'h3C) |-> rdata == REV_WORD);

  assert_ctrl_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q));

endmodule

// File: tb/tri_timer_bench.sv
`timescale 1ns/1ps
module tri_timer_bench;

  localparam logic [11:0] CTL_DEF = 12'hF6D;
  localparam logic [7:0]  A_CTRL = 8'h30, A_STAT = 8'h34, A_MASK = 8'h38, A_REV = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_all;
  logic [2:0]  irq_sub;

  always #2 clk = ~clk;

  tri_timer u_tri_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_all(irq_all), .irq_sub(irq_sub)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench-side model
  logic [31:0] m_cnt [3];
  logic [31:0] m_rld [3];
  logic [31:0] m_ma  [3];
  logic [31:0] m_mb  [3];
  bit          m_arma [3];
  bit          m_armb [3];
  logic [11:0] m_ctl;
  logic [8:0]  m_msk, m_st;
  logic [3:0]  exp_irq;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input bit we, input logic [7:0] a,
                            input logic [31:0] d, input bit tk);
    logic [8:0]  ev;
    logic [8:0]  clr;
    logic [31:0] nx;
    bit          up;
    int          ix;
    ev  = '0;
    clr = '0;
    for (int i = 0; i < 3; i++) begin
      up = m_ctl[9+i];
      if (we && a == 8'(16*i)) begin
        // counter write takes priority (R4)
      end else if (tk && m_ctl[3*i]) begin
        if ((up && m_cnt[i] == 32'hFFFF_FFFF) || (!up && m_cnt[i] == 32'd0)) begin
          m_cnt[i]  = m_rld[i];
          m_arma[i] = 1;
          m_armb[i] = 1;
          if (m_ctl[3*i+2]) ev[3*i+2] = 1'b1;
        end else begin
          nx = up ? m_cnt[i] + 32'd1 : m_cnt[i] - 32'd1;
          if (m_arma[i] && (up ? nx >= m_ma[i] : nx <= m_ma[i])) begin
            ev[3*i] = 1'b1; m_arma[i] = 0;
          end
          if (m_armb[i] && (up ? nx >= m_mb[i] : nx <= m_mb[i])) begin
            ev[3*i+1] = 1'b1; m_armb[i] = 0;
          end
          m_cnt[i] = nx;
        end
      end
    end
    for (int i = 0; i < 3; i++)
      exp_irq[i] = |(ev[3*i +: 3] & ~m_msk[3*i +: 3]);
    exp_irq[3] = |exp_irq[2:0];
    if (we) begin
      if (a < 8'h30 && a[1:0] == 2'b00) begin
        ix = int'(a[5:4]);
        case (a[3:2])
          2'd0: begin m_cnt[ix] = d; m_arma[ix] = 1; m_armb[ix] = 1; end
          2'd1: m_rld[ix] = d;
          2'd2: m_ma[ix]  = d;
          default: m_mb[ix] = d;
        endcase
      end else if (a == A_CTRL) begin
        m_ctl = d[11:0] & CTL_DEF;
        for (int i = 0; i < 3; i++) begin m_arma[i] = 1; m_armb[i] = 1; end
      end else if (a == A_STAT) begin
        clr = d[8:0];
      end else if (a == A_MASK) begin
        m_msk = d[8:0];
      end
    end
    m_st = (m_st & ~clr) | ev;
  endtask

  // one clock cycle of stimulus; interrupt pulses checked in the following cycle (R9)
  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d, input bit tk);
    wr_en = we; addr = a; wdata = d; tick_en = tk;
    model_step(we, a, d, tk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; tick_en = 0; addr = '0; wdata = '0;
    chk("R9", "irq {all,sub}", 32'({irq_all, irq_sub}), 32'(exp_irq));
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; rd_en = 1;
    #0.2;
    v = rdata;
    rd_en = 0; addr = '0;
    #0.1;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 3; i++) begin
      rd(8'(16*i), v);
      chk(tag, $sformatf("counter %0d", i), v, m_cnt[i]);
    end
    rd(A_STAT, v);
    chk(tag, "status", v, 32'(m_st));
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; tick_en = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    for (int i = 0; i < 3; i++) begin
      m_cnt[i] = 0; m_rld[i] = 0; m_ma[i] = 0; m_mb[i] = 0; m_arma[i] = 1; m_armb[i] = 1;
    end
    m_ctl = 0; m_msk = 0; m_st = 0; exp_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2: everything clear after reset
    for (int a = 0; a < 16'h3C; a += 4) begin
      rd(8'(a), v);
      chk("R2", $sformatf("reset value @%02h", a), v, 32'd0);
    end
    chk("R2", "irq after reset", 32'({irq_all, irq_sub}), 32'd0);

    // R1: register map read-back
    for (int i = 0; i < 3; i++)
      for (int s = 0; s < 4; s++)
        step(1, 8'(16*i + 4*s), 32'hA500_0000 + 32'(i*16 + s), 0);
    for (int i = 0; i < 3; i++)
      for (int s = 0; s < 4; s++) begin
        rd(8'(16*i + 4*s), v);
        chk("R1", $sformatf("readback @%02h", 16*i + 4*s), v, 32'hA500_0000 + 32'(i*16 + s));
      end
    step(1, A_CTRL, 32'hFFFF_FFFF, 0);
    rd(A_CTRL, v); chk("R1", "control keeps defined bits", v, 32'h0000_0F6D);
    step(1, A_CTRL, 32'd0, 0);
    step(1, A_MASK, 32'hFFFF_FFFF, 0);
    rd(A_MASK, v); chk("R1", "mask width", v, 32'h0000_01FF);
    step(1, A_MASK, 32'd0, 0);
    rd(A_REV, v); chk("R1", "revision word", v, 32'h0001_0801);
    addr = A_REV; #0.2; chk("R1", "idle rdata", rdata, 32'd0); addr = '0;
    step(1, 8'h40, 32'hDEAD_BEEF, 0);
    step(1, 8'h01, 32'hDEAD_BEEF, 0);
    step(1, A_REV, 32'hDEAD_BEEF, 0);
    rd(8'h40, v); chk("R1", "undefined offset 0x40", v, 32'd0);
    rd(8'h05, v); chk("R1", "unaligned offset", v, 32'd0);
    rd(A_REV, v); chk("R1", "revision unwritable", v, 32'h0001_0801);
    rd(8'h00, v); chk("R1", "counter 0 untouched", v, m_cnt[0]);
    rd(A_CTRL, v); chk("R1", "control untouched", v, 32'(m_ctl));
    @(negedge clk);

    // R3 R5 R6 R7: sub-timer 0 counting up through a wrap with overflow enabled
    step(1, 8'h00, 32'hFFFF_FFF8, 0);
    step(1, 8'h04, 32'd10, 0);
    step(1, 8'h08, 32'hFFFF_FFFC, 0);
    step(1, 8'h0C, 32'd12, 0);
    step(1, A_CTRL, 32'h0000_0205, 0);
    for (int k = 0; k < 20; k++) begin
      step(0, 8'h00, 32'd0, 1);
      check_all("R3/R5/R6/R7");
    end
    // R8: partial clear then full clear
    step(1, A_STAT, 32'h0000_0001, 0);
    check_all("R8");
    step(1, A_STAT, 32'h0000_01FF, 0);
    check_all("R8");

    // R3 R5 R6: sub-timer 1 counting down, overflow event disabled
    step(1, 8'h10, 32'd5, 0);
    step(1, 8'h14, 32'd7, 0);
    step(1, 8'h18, 32'd3, 0);
    step(1, 8'h1C, 32'd0, 0);
    step(1, A_CTRL, 32'h0000_0008, 0);
    for (int k = 0; k < 20; k++) begin
      step(0, 8'h00, 32'd0, 1);
      check_all("R3/R5/R6");
    end
    step(1, A_STAT, 32'h0000_01FF, 0);

    // R9: sub-timer 2 fully masked, status still records
    step(1, A_MASK, 32'h0000_01C0, 0);
    step(1, 8'h20, 32'hFFFF_FFFD, 0);
    step(1, 8'h24, 32'd0, 0);
    step(1, 8'h28, 32'd1, 0);
    step(1, 8'h2C, 32'hFFFF_FFFE, 0);
    step(1, A_CTRL, 32'h0000_0940, 0);
    for (int k = 0; k < 10; k++) begin
      step(0, 8'h00, 32'd0, 1);
      check_all("R9");
    end
    step(1, A_STAT, 32'h0000_01FF, 0);

    // R10 R4 R8 R7: all three at once, writes colliding with ticks
    step(1, A_MASK, 32'h0000_0040, 0);
    step(1, 8'h00, 32'hFFFF_FFE0, 0);
    step(1, 8'h04, 32'h0000_0020, 0);
    step(1, 8'h08, 32'hFFFF_FFF0, 0);
    step(1, 8'h0C, 32'h0000_0030, 0);
    step(1, 8'h10, 32'd25, 0);
    step(1, 8'h14, 32'd40, 0);
    step(1, 8'h18, 32'd10, 0);
    step(1, 8'h1C, 32'd30, 0);
    step(1, 8'h20, 32'd0, 0);
    step(1, 8'h24, 32'd0, 0);
    step(1, 8'h28, 32'd15, 0);
    step(1, 8'h2C, 32'd15, 0);
    step(1, A_CTRL, 32'h0000_0B6D, 0);
    for (int k = 0; k < 60; k++) begin
      if (k == 20)          step(1, 8'h10, 32'd100, 1);         // R4
      else if (k == 30)     step(1, A_STAT, 32'h0000_01FF, 1);  // R8
      else if (k == 40)     step(1, A_CTRL, 32'h0000_0B6D, 0);  // R7 re-arm
      else if (k % 7 == 3)  step(0, 8'h00, 32'd0, 0);           // R3 hold
      else                  step(0, 8'h00, 32'd0, 1);
      check_all("R10/R4/R8/R7");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule